// File: doc/BRIEF.md
# Receive Descriptor Frame Writer

This block moves received frames into memory. A MAC hands it bytes one at a time with an end-of-frame marker. For each frame the block first reads the receive descriptor that its current-descriptor pointer names. Each descriptor is four 32-bit words: the status-and-length word, the buffer start address, a reserved word, and the address of the next descriptor. If the engine owns the descriptor, the block packs the frame bytes into words and writes them to the buffer. It then writes back the status word, which also returns ownership to the CPU, and moves its pointer to the next descriptor.

If the descriptor belongs to the CPU, the frame is thrown away and the descriptor-unavailable event is raised. The engine then holds off until a poll-demand strobe arrives, and every frame that arrives while it holds off is also dropped and flagged. An over-length frame is always flagged. With the long-packet control set it is stored in full up to a hard limit; with the control clear it is cut at the standard maximum. Single-cycle event pulses tell a nearby register block what happened, and that block keeps the interrupt status.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset, in_ready and mem_req are 0, no event output is high, and cur_desc equals list_base.
- R2: For each accepted frame the descriptor is read in this order: word 0 at cur_desc, word 1 at cur_desc+4, then word 3 at cur_desc+12. The reserved word at cur_desc+8 is never read or written.
- R3: The engine owns a descriptor when bits 31:30 of word 0 are 2'b10. The written-back status word carries 2'b00 in bits 31:30, which hands the descriptor back to the CPU.
- R4: Frame bytes are stored little-endian: byte k goes to bits 8*(k%4)+7:8*(k%4) of the word at buffer+4*(k/4). A final partial word has zeros in its unused lanes.
- R5: The written-back status word has bit 20 (good) set. Bit 16 (interrupt) is set only when rxint_en is 1.
- R6: Bits 15:0 of the written-back status hold the number of stored bytes plus 4 CRC bytes.
- R7: With accept_long at 1, a frame of up to LONG_MAX bytes (default 2048) is stored in full. A frame longer than STD_MAX (default 1518) also sets status bit 19 (too long). A 1600-byte frame gives status 0x00190644 when rxint_en is 1.
- R8: With accept_long at 0, only the first STD_MAX bytes are stored and the bytes after them leave memory untouched. Bit 19 is still set, and a 1600-byte frame gives status 0x001905F2 when rxint_en is 1.
- R9: After the status write-back, cur_desc equals the next-descriptor address read from word 3.
- R10: On the status write-back, ev_rxintr, ev_rxgd and ev_deni pulse for exactly one cycle. ev_ptle pulses with them only for an over-length frame.
- R11: A frame whose descriptor is CPU-owned is consumed with no memory write and gives one ev_rdu pulse. Until poll_req is seen, each later frame is consumed with no memory access at all and gives one ev_rdu pulse.
- R12: While rx_on or accept_ucast is 0, frames are consumed with no memory access and no event, and cur_desc does not advance. While rx_on is 0 and the block is idle, cur_desc reloads from list_base.
- R13: mem_req stays high, with a stable address and direction, until mem_ack. in_ready is never high while mem_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_on | input | 1 | Receive enable |
| accept_long | input | 1 | Store over-length frames in full |
| accept_ucast | input | 1 | Accept all unicast frames |
| rxint_en | input | 1 | Receive interrupt enable, mirrored into status bit 16 |
| poll_req | input | 1 | Poll-demand strobe that ends a descriptor-unavailable stall |
| list_base | input | 32 | Start address of the descriptor chain |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completes in this cycle |
| cur_desc | output | 32 | Current descriptor address |
| ev_rxintr | output | 1 | Receive interrupt event pulse |
| ev_rxgd | output | 1 | Good frame event pulse |
| ev_deni | output | 1 | DMA early notification event pulse |
| ev_ptle | output | 1 | Frame too long event pulse |
| ev_rdu | output | 1 | Descriptor unavailable event pulse |

## Verification
A completed frame shows up in the same cycle as the acknowledge of its status write. So the bench polls the good-frame event counter on falling edges and reads memory, cur_desc and the counters only after that counter has moved. A drop for ownership appears on the acknowledge of the first descriptor read, and a drop during a stall appears in the first idle cycle that sees the byte. For both cases the bench waits a few cycles after the last byte is accepted before it compares the access and event counters. Bytes are presented on falling edges and counted as taken on the next rising edge only if in_ready was already high.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_FETCH_ST, S_FETCH_BUF, S_FETCH_NXT,
      S_RECV, S_FLUSH, S_WB, S_DROP
   } rxd_state_e;

   localparam logic [1:0] OWN_ENGINE = 2'b10;
   localparam logic [1:0] OWN_CPU    = 2'b00;
   localparam int OWN_LO    = 30;
   localparam int GOOD_BIT  = 20;
   localparam int LONG_BIT  = 19;
   localparam int IRQ_BIT   = 16;
   localparam int BUF_WORD  = 1;
   localparam int NEXT_WORD = 3;
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
   parameter int BYTE_W  = 8,
   parameter int LANES   = 4,
   parameter bit BIG_END = 1'b0,
   localparam int CNT_W  = $clog2(LANES + 1),
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      push,
   input  logic [BYTE_W-1:0]         din,
   output logic [LANES*BYTE_W-1:0]   word,
   output logic [CNT_W-1:0]          cnt
);
   logic [LANE_W-1:0] lane;

   generate
      if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("rxd_packer: LANES must be a power of two");
      end
      if (BIG_END) begin : g_big
         assign lane = LANE_W'(LANES - 1) - cnt[LANE_W-1:0];
      end else begin : g_little
         assign lane = cnt[LANE_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         word <= '0;
         cnt  <= '0;
      end else if (push) begin
         word[lane*BYTE_W +: BYTE_W] <= din;
         cnt <= cnt + CNT_W'(1);
      end
   end

   // R4
   pack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt < CNT_W'(LANES)));
endmodule

// File: rtl/rxd_status.sv
module rxd_status #(
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 16,
   parameter int CRC_BYTES = 4
) (
   input  logic [LEN_W-1:0]  kept,
   input  logic              long_flag,
   input  logic              irq_en,
   output logic [DATA_W-1:0] status
);
   import rxd_pkg::*;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("rxd_status: status word must be 32 bits");
      end
      if (LEN_W > 16) begin : g_bad_len
         $error("rxd_status: length field is 16 bits");
      end
   endgenerate

   always_comb begin
      status = '0;
      status[OWN_LO +: 2] = OWN_CPU;
      status[GOOD_BIT]    = 1'b1;
      status[LONG_BIT]    = long_flag;
      status[IRQ_BIT]     = irq_en;
      status[LEN_W-1:0]   = kept + LEN_W'(CRC_BYTES);
   end
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer #(
   parameter int ADDR_W    = 32,
   parameter int BYTE_W    = 8,
   parameter int LANES     = 4,
   parameter int LEN_W     = 16,
   parameter int STD_MAX   = 1518,
   parameter int LONG_MAX  = 2048,
   parameter int CRC_BYTES = 4,
   parameter bit BIG_END   = 1'b0,
   localparam int DATA_W   = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_on,
   input  logic              accept_long,
   input  logic              accept_ucast,
   input  logic              rxint_en,
   input  logic              poll_req,
   input  logic [ADDR_W-1:0] list_base,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic [ADDR_W-1:0] cur_desc,
   output logic              ev_rxintr,
   output logic              ev_rxgd,
   output logic              ev_deni,
   output logic              ev_ptle,
   output logic              ev_rdu
);
   import rxd_pkg::*;

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int CNT_W      = $clog2(LANES + 1);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("rx_desc_writer: byte lanes must be 8 bits");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("rx_desc_writer: address wider than data word");
      end
      if (STD_MAX >= LONG_MAX || LONG_MAX + CRC_BYTES >= (1 << LEN_W)) begin : g_bad_lim
         $error("rx_desc_writer: frame limits do not fit");
      end
   endgenerate

   rxd_state_e        state;
   logic [ADDR_W-1:0] cur_q, nxt_q, wptr_q;
   logic [LEN_W-1:0]  seen_q, kept_q, limit;
   logic              long_q, stall_q, eof_q;
   logic [DATA_W-1:0] pk_word, status_w;
   logic [CNT_W-1:0]  pk_cnt, fill_nx;
   logic              accept, push, pk_clr, done, own_ok, over;

   assign in_ready = (state == S_RECV) || (state == S_DROP);
   assign accept   = in_valid && in_ready;
   assign limit    = accept_long ? LEN_W'(LONG_MAX) : LEN_W'(STD_MAX);
   assign push     = accept && (state == S_RECV) && (kept_q < limit);
   assign fill_nx  = pk_cnt + CNT_W'(push);
   assign over     = seen_q >= LEN_W'(STD_MAX);
   assign own_ok   = mem_rdata[OWN_LO +: 2] == OWN_ENGINE;
   assign done     = (state == S_WB) && mem_ack;
   assign pk_clr   = mem_ack && ((state == S_FETCH_NXT) || (state == S_FLUSH));

   rxd_packer #(.BYTE_W(BYTE_W), .LANES(LANES), .BIG_END(BIG_END)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(pk_clr), .push(push),
      .din(in_data), .word(pk_word), .cnt(pk_cnt));

   rxd_status #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CRC_BYTES(CRC_BYTES)) u_stat (
      .kept(kept_q), .long_flag(long_q), .irq_en(rxint_en), .status(status_w));

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = cur_q;
      unique case (state)
         S_FETCH_ST:  mem_req = 1'b1;
         S_FETCH_BUF: begin
            mem_req  = 1'b1;
            mem_addr = cur_q + ADDR_W'(BUF_WORD * WORD_BYTES);
         end
         S_FETCH_NXT: begin
            mem_req  = 1'b1;
            mem_addr = cur_q + ADDR_W'(NEXT_WORD * WORD_BYTES);
         end
         S_FLUSH: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = wptr_q;
         end
         S_WB: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end

   assign mem_wdata = (state == S_FLUSH) ? pk_word : status_w;
   assign cur_desc  = cur_q;
   assign ev_rxgd   = done;
   assign ev_rxintr = done;
   assign ev_deni   = done;
   assign ev_ptle   = done && long_q;
   assign ev_rdu    = ((state == S_FETCH_ST) && mem_ack && !own_ok) ||
                      ((state == S_IDLE) && in_valid && rx_on && accept_ucast && stall_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cur_q   <= list_base;
         nxt_q   <= '0;
         wptr_q  <= '0;
         seen_q  <= '0;
         kept_q  <= '0;
         long_q  <= 1'b0;
         stall_q <= 1'b0;
         eof_q   <= 1'b0;
      end else begin
         if (poll_req) stall_q <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (!rx_on) cur_q <= list_base;
               if (in_valid) begin
                  if (!rx_on || !accept_ucast || stall_q) state <= S_DROP;
                  else state <= S_FETCH_ST;
               end
            end
            S_FETCH_ST: if (mem_ack) begin
               if (own_ok) state <= S_FETCH_BUF;
               else begin
                  stall_q <= 1'b1;
                  state   <= S_DROP;
               end
            end
            S_FETCH_BUF: if (mem_ack) begin
               wptr_q <= mem_rdata[ADDR_W-1:0];
               state  <= S_FETCH_NXT;
            end
            S_FETCH_NXT: if (mem_ack) begin
               nxt_q  <= mem_rdata[ADDR_W-1:0];
               seen_q <= '0;
               kept_q <= '0;
               long_q <= 1'b0;
               state  <= S_RECV;
            end
            S_RECV: if (accept) begin
               if (seen_q != '1) seen_q <= seen_q + LEN_W'(1);
               if (push) kept_q <= kept_q + LEN_W'(1);
               if (over) long_q <= 1'b1;
               if (in_last) begin
                  eof_q <= 1'b1;
                  state <= (fill_nx != '0) ? S_FLUSH : S_WB;
               end else if (fill_nx == CNT_W'(LANES)) begin
                  eof_q <= 1'b0;
                  state <= S_FLUSH;
               end
            end
            S_FLUSH: if (mem_ack) begin
               wptr_q <= wptr_q + ADDR_W'(WORD_BYTES);
               state  <= eof_q ? S_WB : S_RECV;
            end
            S_WB: if (mem_ack) begin
               cur_q <= nxt_q;
               state <= S_IDLE;
            end
            S_DROP: if (accept && in_last) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   // R13
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R13
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && mem_req));

   // R10
   ev_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rxgd |=> !ev_rxgd);

   // R11
   rdu_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rdu |-> !ev_rxgd && !ev_ptle);

   // R9
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_rxgd && !(state == S_IDLE && !rx_on)) |=> $stable(cur_desc));
endmodule

// File: tb/rx_desc_writer_test.sv
`timescale 1ns/1ps
module rx_desc_writer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_on = 1'b0, accept_long = 1'b0, accept_ucast = 1'b1;
   logic        rxint_en = 1'b1, poll_req = 1'b0;
   logic [31:0] list_base = 32'h100;
   logic        in_valid = 1'b0, in_last = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, cur_desc;
   logic        ev_rxintr, ev_rxgd, ev_deni, ev_ptle, ev_rdu;

   logic        host_we = 1'b0;
   logic [31:0] host_addr = '0, host_data = '0;
   logic [31:0] mem [0:4095];
   int ops = 0, n_gd = 0, n_intr = 0, n_deni = 0, n_ptle = 0, n_rdu = 0;
   logic [31:0] rd0 = '0, rd1 = '0, rd2 = '0;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rx_desc_writer uut (
      .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .accept_long(accept_long),
      .accept_ucast(accept_ucast), .rxint_en(rxint_en), .poll_req(poll_req),
      .list_base(list_base), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .cur_desc(cur_desc),
      .ev_rxintr(ev_rxintr), .ev_rxgd(ev_rxgd), .ev_deni(ev_deni),
      .ev_ptle(ev_ptle), .ev_rdu(ev_rdu));

   always @(posedge clk) begin
      if (host_we) mem[host_addr[13:2]] <= host_data;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         ops <= ops + 1;
         if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
         else begin
            mem_rdata <= mem[mem_addr[13:2]];
            rd2 <= rd1; rd1 <= rd0; rd0 <= mem_addr;
         end
      end else mem_ack <= 1'b0;
      if (ev_rxgd)   n_gd   <= n_gd + 1;
      if (ev_rxintr) n_intr <= n_intr + 1;
      if (ev_deni)   n_deni <= n_deni + 1;
      if (ev_ptle)   n_ptle <= n_ptle + 1;
      if (ev_rdu)    n_rdu  <= n_rdu + 1;
   end

   function automatic logic [31:0] peek(input logic [31:0] a);
      return mem[a[13:2]];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_data = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic set_desc(input logic [31:0] a, input logic [31:0] st,
                           input logic [31:0] buf_a, input logic [31:0] nx);
      poke(a, st);
      poke(a + 4, buf_a);
      poke(a + 8, 32'hDEADBEEF);
      poke(a + 12, nx);
   endtask

   task automatic send_frame(input int n, input logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = seed + 8'(i);
         in_last  = (i == n - 1);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic wait_gd(input int target);
      for (int i = 0; i < 6000 && n_gd < target; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 in_ready", {31'd0, in_ready}, 32'd0);
      chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
      chk("R1 events", {27'd0, ev_rxintr, ev_rxgd, ev_deni, ev_ptle, ev_rdu}, 32'd0);
      chk("R1 cur_desc", cur_desc, 32'h100);
   endtask

   task automatic t_good_irq;
      rxint_en = 1'b1;
      send_frame(6, 8'h11);
      wait_gd(1);
      chk("R2 first read", rd2, 32'h100);
      chk("R2 second read", rd1, 32'h104);
      chk("R2 third read", rd0, 32'h10C);
      chk("R2 reserved untouched", peek(32'h108), 32'hDEADBEEF);
      chk("R4 word0", peek(32'h1000), 32'h14131211);
      chk("R4 partial word", peek(32'h1004), 32'h00001615);
      chk("R3 R5 R6 status", peek(32'h100), 32'h0011000A);
      chk("R9 cur_desc", cur_desc, 32'h110);
      chk("R10 rxgd count", n_gd, 1);
      chk("R10 rxintr count", n_intr, 1);
      chk("R10 deni count", n_deni, 1);
      chk("R10 ptle count", n_ptle, 0);
   endtask

   task automatic t_good_noirq;
      rxint_en = 1'b0;
      send_frame(5, 8'h40);
      wait_gd(2);
      chk("R4 word0 frame2", peek(32'h1800), 32'h43424140);
      chk("R4 partial frame2", peek(32'h1804), 32'h00000044);
      chk("R5 status no irq", peek(32'h110), 32'h00100009);
      chk("R9 cur_desc frame2", cur_desc, 32'h120);
   endtask

   task automatic t_unavailable;
      int ops0;
      rxint_en = 1'b1;
      ops0 = ops;
      send_frame(8, 8'h70);
      repeat (4) @(negedge clk);
      chk("R11 single read only", ops - ops0, 1);
      chk("R11 status untouched", peek(32'h120), 32'h0);
      chk("R11 rdu pulse", n_rdu, 1);
      chk("R11 cur_desc held", cur_desc, 32'h120);
      ops0 = ops;
      send_frame(4, 8'h80);
      repeat (4) @(negedge clk);
      chk("R11 stalled no access", ops - ops0, 0);
      chk("R11 stalled rdu", n_rdu, 2);
      chk("R11 no good event", n_gd, 2);
   endtask

   task automatic t_long_kept;
      poke(32'h120, 32'h80000000);
      poke(32'h124, 32'h2000);
      poke(32'h12C, 32'h140);
      @(negedge clk); poll_req = 1'b1;
      @(negedge clk); poll_req = 1'b0;
      accept_long = 1'b1;
      send_frame(1600, 8'h00);
      wait_gd(3);
      chk("R7 first word", peek(32'h2000), 32'h03020100);
      chk("R7 last word", peek(32'h263C), 32'h3F3E3D3C);
      chk("R7 status", peek(32'h120), 32'h00190644);
      chk("R10 ptle pulse", n_ptle, 1);
      chk("R9 cur_desc long", cur_desc, 32'h140);
   endtask

   task automatic t_truncate;
      set_desc(32'h140, 32'h80000000, 32'h2800, 32'h150);
      poke(32'h2DF0, 32'hA5A5A5A5);
      accept_long = 1'b0;
      send_frame(1600, 8'h00);
      wait_gd(4);
      chk("R8 last kept word", peek(32'h2DEC), 32'h0000EDEC);
      chk("R8 beyond limit untouched", peek(32'h2DF0), 32'hA5A5A5A5);
      chk("R8 status", peek(32'h140), 32'h001905F2);
      chk("R8 ptle pulse", n_ptle, 2);
   endtask

   task automatic t_disabled;
      int ops0, gd0;
      set_desc(32'h150, 32'h80000000, 32'h2F00, 32'h160);
      ops0 = ops; gd0 = n_gd;
      accept_ucast = 1'b0;
      send_frame(4, 8'h90);
      repeat (4) @(negedge clk);
      chk("R12 ucast off no access", ops - ops0, 0);
      chk("R12 ucast off no event", n_gd - gd0, 0);
      chk("R12 ucast off cur_desc", cur_desc, 32'h150);
      accept_ucast = 1'b1;
      rx_on = 1'b0;
      send_frame(4, 8'hA0);
      repeat (4) @(negedge clk);
      chk("R12 rx off no access", ops - ops0, 0);
      chk("R12 rx off no rdu", n_rdu, 2);
      chk("R12 rx off reload", cur_desc, 32'h100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      set_desc(32'h100, 32'h80000000, 32'h1000, 32'h110);
      set_desc(32'h110, 32'h80000000, 32'h1800, 32'h120);
      set_desc(32'h120, 32'h00000000, 32'h2000, 32'h140);
      @(negedge clk);
      rx_on = 1'b1;
      t_good_irq();
      t_good_noirq();
      t_unavailable();
      t_long_kept();
      t_truncate();
      t_disabled();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule